// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

This block receives 8-bit characters from one asynchronous serial line. A free-running 12-bit prescaler on the system clock gives a reference tick. A run-time tap select `n` (0 to 11) sets the tick period to 2^(n+1) system clocks. Bit timing counts these ticks. A falling line in idle is checked again partway into the bit before the receiver accepts it as a start bit. Then eight data bits (least significant first), an optional parity bit and a stop bit are sampled, one per bit period.

At the end of the stop bit the byte goes into a holding register, whether or not the frame had an error. A completion pulse and an error pulse report the result, and a mask input can hide the completion pulse for errored frames. Sticky flags report framing, parity and overrun errors until software strobes a read of the holding register. Clearing the enable stops any frame in progress and leaves no trace.

Top module: `serial_rx`

## Requirements
- R1: The reference tick occurs once every 2^(n+1) system clocks for tap select n in 0..11, so one bit lasts BIT_TICKS·2^(n+1) clocks. Frames sent at that rate are received correctly for more than one tap value.
- R2: A low level in idle is treated as a start bit only if the line is still low START_TICKS ticks later. A shorter low pulse produces no pulse, no data and no flag change, and a proper frame that follows is received normally.
- R3: Eight data bits are taken least significant first and loaded into `rx_data` when the stop bit is sampled. `rx_done` pulses for exactly one clock for an error-free frame.
- R4: `par_mode` encoding is 0 = no parity bit, 1 = even, 2 = odd, 3 = no parity bit. When parity is enabled, a parity bit that does not match the data sets `flag_pe`.
- R5: A low stop bit sets `flag_fe`. The errored byte is still loaded into `rx_data`.
- R6: Any frame error produces a one-clock `rx_err` pulse. `rx_done` also pulses for that frame when `err_mask` is 0, and stays low when `err_mask` is 1.
- R7: If a frame completes while the previous byte is still unread, `flag_ovr` is set and the new byte replaces the old one. The flag stays set through later frames until a read.
- R8: A one-clock `buf_rd` strobe clears `flag_fe`, `flag_pe` and `flag_ovr` and marks the holding register as read.
- R9: While `rx_en` is 0 the line is ignored. Dropping `rx_en` in mid-frame abandons the frame: `rx_data` and the flags are unchanged, and neither pulse fires.
- R10: After reset `rx_data` is 0, all flags are 0 and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| tap_sel | input | 4 | Prescaler tap n; values above 11 act as 11 |
| par_mode | input | 2 | Parity mode (see R4) |
| err_mask | input | 1 | 1 hides the completion pulse for errored frames |
| buf_rd | input | 1 | Read strobe for the holding register |
| rx_data | output | 8 | Last received byte |
| rx_done | output | 1 | Completion pulse |
| rx_err | output | 1 | Error pulse |
| flag_fe | output | 1 | Sticky framing error |
| flag_pe | output | 1 | Sticky parity error |
| flag_ovr | output | 1 | Sticky overrun error |

## Verification
The bench sends all 256 byte values across the four parity codes and also runs frames at a second tap. A bit-order or prescaler fault therefore corrupts many bytes rather than one. It injects a start glitch shorter than the validation delay; a receiver that skips the second look would shift in a spurious frame. Parity and stop errors are sent under both mask settings, to catch a design that drops the errored byte or lets the completion pulse through when it is masked. Back-to-back unread frames check that the overrun flag sets and persists. A frame cut off by clearing the enable checks that an earlier byte and its flags survive untouched.

// File: rtl/serial_rx.sv
module serial_rx #(
  parameter int BIT_TICKS   = 16,
  parameter int START_TICKS = 8,
  parameter int PRE_W       = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       rx_en,
  input  logic [3:0] tap_sel,
  input  logic [1:0] par_mode,
  input  logic       err_mask,
  input  logic       buf_rd,
  output logic [7:0] rx_data,
  output logic       rx_done,
  output logic       rx_err,
  output logic       flag_fe,
  output logic       flag_pe,
  output logic       flag_ovr
);
  localparam int CW = $clog2(BIT_TICKS + 1);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t             st;
  logic [1:0]      sync;
  logic            rx_s;
  logic [PRE_W-1:0] pre, mask;
  logic [3:0]      tap;
  logic            tick;
  logic [CW-1:0]   cnt;
  logic [2:0]      idx;
  logic [7:0]      sh;
  logic            pbit, full;
  logic            bit_end, start_end, fin, par_on;
  logic            fe_n, pe_n, ovr_n, any_err;

  assign rx_s = sync[1];
  assign tap  = (tap_sel > 4'(PRE_W - 1)) ? 4'(PRE_W - 1) : tap_sel;
  assign mask = (PRE_W'(2) << tap) - PRE_W'(1);
  assign tick = (pre & mask) == mask;

  assign bit_end   = tick && cnt == CW'(BIT_TICKS - 1);
  assign start_end = tick && cnt == CW'(START_TICKS - 1);
  assign par_on    = par_mode == 2'd1 || par_mode == 2'd2;
  assign fin       = rx_en && st == S_STOP && bit_end;

  assign fe_n    = !rx_s;
  assign pe_n    = par_on && ((^{sh, pbit}) != (par_mode == 2'd2));
  assign ovr_n   = full && !buf_rd;
  assign any_err = fe_n || pe_n || ovr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      pre  <= '0;
    end else begin
      sync <= {sync[0], rx_in};
      pre  <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else if (!rx_en) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (!rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (start_end) begin
            cnt <= '0;
            idx <= '0;
            st  <= rx_s ? S_IDLE : S_DATA;
          end else if (tick) cnt <= cnt + 1'b1;
        S_DATA:
          if (bit_end) begin
            cnt <= '0;
            sh  <= {rx_s, sh[7:1]};
            idx <= idx + 1'b1;
            if (idx == 3'd7) st <= par_on ? S_PAR : S_STOP;
          end else if (tick) cnt <= cnt + 1'b1;
        S_PAR:
          if (bit_end) begin
            cnt  <= '0;
            pbit <= rx_s;
            st   <= S_STOP;
          end else if (tick) cnt <= cnt + 1'b1;
        S_STOP:
          if (bit_end) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else if (tick) cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      full     <= 1'b0;
      flag_fe  <= 1'b0;
      flag_pe  <= 1'b0;
      flag_ovr <= 1'b0;
      rx_done  <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      rx_done <= fin && !(any_err && err_mask);
      rx_err  <= fin && any_err;
      if (fin) begin
        rx_data  <= sh;
        full     <= 1'b1;
        flag_fe  <= (flag_fe  && !buf_rd) || fe_n;
        flag_pe  <= (flag_pe  && !buf_rd) || pe_n;
        flag_ovr <= (flag_ovr && !buf_rd) || ovr_n;
      end else if (buf_rd) begin
        full     <= 1'b0;
        flag_fe  <= 1'b0;
        flag_pe  <= 1'b0;
        flag_ovr <= 1'b0;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rx_done |=> !rx_done); // R3
  AST_ERR_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) rx_err |-> (flag_fe || flag_pe || flag_ovr)); // R6
  AST_MASK_HIDES_DONE: assert property (@(posedge clk) disable iff (!rst_n) (rx_err && $past(err_mask)) |-> !rx_done); // R6
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag_ovr) |-> $past(full)); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (buf_rd && !fin) |=> !(flag_fe || flag_pe || flag_ovr)); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !rx_en |=> (!rx_done && !rx_err)); // R9
  AST_DISABLED_DATA: assert property (@(posedge clk) disable iff (!rst_n) !rx_en |=> $stable(rx_data)); // R9
endmodule

// File: tb/serial_rx_bench.sv
module serial_rx_bench;
  localparam int BT = 8;
  localparam int ST = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       rx_en = 1'b0;
  logic [3:0] tap_sel = 4'd0;
  logic [1:0] par_mode = 2'd0;
  logic       err_mask = 1'b0;
  logic       buf_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_done, rx_err, flag_fe, flag_pe, flag_ovr;

  int n_tests = 0;
  int n_fail  = 0;
  int n_done  = 0;
  int n_err   = 0;
  int bc      = BT * 2;

  serial_rx #(.BIT_TICKS(BT), .START_TICKS(ST)) u_serial_rx (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_en(rx_en), .tap_sel(tap_sel),
    .par_mode(par_mode), .err_mask(err_mask), .buf_rd(buf_rd), .rx_data(rx_data),
    .rx_done(rx_done), .rx_err(rx_err), .flag_fe(flag_fe), .flag_pe(flag_pe),
    .flag_ovr(flag_ovr));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rx_done) n_done <= n_done + 1;
    if (rx_err)  n_err  <= n_err + 1;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail = n_fail + 1;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests = n_tests + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx_in = b;
    repeat (bc) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    logic p;
    drive_bit(1'b0);
    for (int k = 0; k < 8; k++) drive_bit(d[k]);
    if (par_mode == 2'd1 || par_mode == 2'd2) begin
      p = (par_mode == 2'd1) ? ^d : ~^d;
      drive_bit(p ^ bad_par);
    end
    drive_bit(!bad_stop);
    rx_in = 1'b1;
    repeat (2 * bc) @(negedge clk);
  endtask

  task automatic read_buf();
    buf_rd = 1'b1;
    @(negedge clk);
    buf_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int d0, e0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 data", rx_data, 0);
    check("R10 flags", {flag_fe, flag_pe, flag_ovr}, 0);
    check("R10 pulses", {rx_done, rx_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 disabled line ignored
    d0 = n_done; e0 = n_err;
    send(8'hA5, 1'b0, 1'b0);
    check("R9 disabled no pulse", n_done + n_err, d0 + e0);
    check("R9 disabled data kept", rx_data, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R2 start glitch
    d0 = n_done;
    rx_in = 1'b0;
    repeat (2) @(negedge clk);
    rx_in = 1'b1;
    repeat (4 * bc) @(negedge clk);
    check("R2 glitch no done", n_done, d0);
    check("R2 glitch no data", rx_data, 0);
    send(8'h3C, 1'b0, 1'b0);
    check("R2 after glitch data", rx_data, 8'h3C);
    check("R2 after glitch done", n_done, d0 + 1);
    read_buf();

    // R3 R4 sweep of all bytes and parity codes
    for (int i = 0; i < 256; i++) begin
      par_mode = 2'(i % 4);
      d0 = n_done; e0 = n_err;
      send(8'(i), 1'b0, 1'b0);
      check("R3 data", rx_data, i);
      check("R3 one done", n_done, d0 + 1);
      check("R4 no error", n_err, e0);
      check("R4 flags clear", {flag_fe, flag_pe, flag_ovr}, 0);
      read_buf();
    end

    // R1 second tap
    tap_sel = 4'd1; bc = BT * 4;
    repeat (4 * bc) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      par_mode = 2'(i % 3);
      d0 = n_done;
      send(8'(8'h5A + 37 * i), 1'b0, 1'b0);
      check("R1 tap1 data", rx_data, 8'(8'h5A + 37 * i));
      check("R1 tap1 done", n_done, d0 + 1);
      read_buf();
    end
    tap_sel = 4'd0; bc = BT * 2;
    repeat (4 * bc) @(negedge clk);

    // R4 R6 parity error unmasked
    par_mode = 2'd1; err_mask = 1'b0;
    d0 = n_done; e0 = n_err;
    send(8'h81, 1'b1, 1'b0);
    check("R4 even pe", flag_pe, 1);
    check("R6 unmasked done", n_done, d0 + 1);
    check("R6 err pulse", n_err, e0 + 1);
    check("R5 errored data loaded", rx_data, 8'h81);
    read_buf();
    check("R8 read clears pe", flag_pe, 0);

    // R4 R6 odd parity error masked
    par_mode = 2'd2; err_mask = 1'b1;
    d0 = n_done; e0 = n_err;
    send(8'h7E, 1'b1, 1'b0);
    check("R4 odd pe", flag_pe, 1);
    check("R6 masked no done", n_done, d0);
    check("R6 masked err pulse", n_err, e0 + 1);
    check("R6 masked data loaded", rx_data, 8'h7E);
    read_buf();

    // R5 framing error
    par_mode = 2'd0; err_mask = 1'b0;
    d0 = n_done; e0 = n_err;
    send(8'hC3, 1'b0, 1'b1);
    check("R5 fe", flag_fe, 1);
    check("R5 data", rx_data, 8'hC3);
    check("R5 err pulse", n_err, e0 + 1);
    read_buf();
    check("R8 read clears fe", flag_fe, 0);

    // R7 overrun
    send(8'h11, 1'b0, 1'b0);
    check("R7 first no ovr", flag_ovr, 0);
    e0 = n_err;
    send(8'h22, 1'b0, 1'b0);
    check("R7 ovr set", flag_ovr, 1);
    check("R7 newer data", rx_data, 8'h22);
    check("R7 err pulse", n_err, e0 + 1);
    send(8'h33, 1'b0, 1'b0);
    check("R7 ovr persists", flag_ovr, 1);
    read_buf();
    check("R8 read clears ovr", flag_ovr, 0);

    // R9 abort mid-frame after an unread parity error
    par_mode = 2'd1;
    send(8'h44, 1'b1, 1'b0);
    d0 = n_done; e0 = n_err;
    drive_bit(1'b0);
    for (int k = 0; k < 4; k++) drive_bit(k[0]);
    rx_en = 1'b0;
    for (int k = 0; k < 7; k++) drive_bit(1'b0);
    rx_in = 1'b1;
    repeat (3 * bc) @(negedge clk);
    check("R9 abort no pulse", n_done + n_err, d0 + e0);
    check("R9 abort data kept", rx_data, 8'h44);
    check("R9 abort flags kept", {flag_fe, flag_pe, flag_ovr}, 3'b010);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    read_buf();
    send(8'h99, 1'b0, 1'b0);
    check("R9 resume data", rx_data, 8'h99);
    check("R9 resume flags", {flag_fe, flag_pe, flag_ovr}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule